// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one 8-bit compare channel that sits beside a timer/counter. On every cycle in which the timer clock enable is high, it compares the live counter value with its active compare value. On equality it raises a sticky match flag and acts on an output pin: it sets, clears or toggles the pin, or leaves it alone, as a two-bit output mode selects. The counter, its reload logic and the interrupt controller are outside the block. The block only sees the counter value, the top and bottom strobes, and a pulse that says software has just written the counter.

The compare value is loaded in one of two ways, chosen by the waveform mode:

- **Normal and clear-on-compare modes:** a CPU write goes straight into the active register.
- **PWM modes:** a CPU write lands in a shadow register. The active register copies it only at a cycle boundary. Fast PWM copies it at the top of the count and phase-correct PWM at the bottom. This stops a mid-period write from producing a short or lopsided pulse.

Two further features:

- **Software force strobe:** it drives the pin as if a match had happened. It works only in the non-PWM modes and never sets the flag.
- **Match blocking after a counter write:** a counter write masks matches for the next enabled timer cycle. Software can therefore preload equal counter and compare values without a spurious match.

Top module: `timer_cmp_channel`

## Requirements
- R1: When `tick` is high and `count_val` equals the active compare value, `match_flag` is 1 and the pin action is applied from the next clock edge on.
- R2: A cycle with `tick` low produces no match, even if `count_val` equals the active compare value.
- R3: `out_mode` selects the pin action taken on a match or force: 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R4: In the non-buffered modes (`wave_mode` 00 normal and 10 clear-on-compare), a `cmp_wr` loads `cmp_wdata` into the active compare value at the next clock edge.
- R5: In the PWM modes (`wave_mode` 11 fast and 01 phase-correct), `cmp_wr` loads only the shadow register. The active value copies the shadow on a `tick` cycle with `at_top` high (fast) or with `at_bottom` high (phase-correct), and at no other time.
- R6: `cmp_rdata` returns the shadow register in the PWM modes and the active compare value in the non-buffered modes.
- R7: `force_cmp` in a non-buffered mode applies the R3 pin action at the next edge without setting `match_flag`. In a PWM mode `force_cmp` has no effect on the pin.
- R8: A `cnt_wr` pulse, given with `tick` high or low, blocks any match in the next cycle that has `tick` high. Matching resumes on the enabled cycle after that one.
- R9: `match_flag` stays set until a `flag_clr` pulse clears it. A match in the same cycle as `flag_clr` wins, and the flag stays 1.
- R10: After reset, `pin_out`, `match_flag`, the shadow register and the active compare value are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable; matches and shadow loads happen only when high |
| count_val | input | 8 | Current counter value |
| at_top | input | 1 | Counter is at the top of its sequence |
| at_bottom | input | 1 | Counter is at the bottom of its sequence |
| wave_mode | input | 2 | 00 normal, 01 phase-correct PWM, 10 clear-on-compare, 11 fast PWM |
| out_mode | input | 2 | Pin action on a match: 00 none, 01 toggle, 10 clear, 11 set |
| cmp_wr | input | 1 | CPU write strobe for the compare value |
| cmp_wdata | input | 8 | CPU write data |
| cmp_rdata | output | 8 | CPU readback of the compare value |
| cnt_wr | input | 1 | Pulse marking a CPU write to the counter |
| force_cmp | input | 1 | Software force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear strobe for the match flag |
| match_flag | output | 1 | Sticky compare match flag |
| pin_out | output | 1 | Compare output pin |

## Verification
The bench checks the following corner cases, each against a specific wrong design:

- **Shadow load timing:** it writes a new value in fast PWM, sends a bottom strobe that must be ignored, then a top strobe. A design that loaded at the wrong end, or loaded at once, would match the new value too early. A design that never loaded would miss it later. The mirror case checks phase-correct PWM.
- **Counter write while stopped:** it writes the counter with the timer stopped and then presents a match. A design that dropped the block when no tick was present, or held it for more than one enabled cycle, would show the flag in the wrong cycle.
- **Forced compare:** the bench checks that the pin moves while the flag stays low, and that the same strobe in PWM mode leaves the pin alone.
- **Clear against match:** it issues a flag clear in the same cycle as a match. A design that gave the clear priority would lose the event.

// File: rtl/tcmp_pkg.sv
// Package tcmp_pkg
// Shared encodings and helpers for the timer compare channel.
// Assumes wave_mode bit 0 set means a PWM (buffered) mode.
package tcmp_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL       = 2'b00,
        WM_PWM_PHASE    = 2'b01,
        WM_CLEAR_ON_CMP = 2'b10,
        WM_PWM_FAST     = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } out_mode_e;

    // True for the two modes that buffer the compare value.
    function automatic logic mode_is_pwm(input wave_mode_e m);
        return (m == WM_PWM_PHASE) || (m == WM_PWM_FAST);
    endfunction

    // Next pin level for a given action and current level.
    function automatic logic pin_action(input out_mode_e om, input logic cur);
        logic nxt;
        case (om)
            OM_TOGGLE: nxt = ~cur;
            OM_CLEAR:  nxt = 1'b0;
            OM_SET:    nxt = 1'b1;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tcmp_regs.sv
// Module tcmp_regs
// Holds the shadow and active compare registers and the CPU readback mux.
// Assumes load_evt is already qualified with the timer clock enable.
module tcmp_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buffered,
    input  logic         load_evt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] active,
    output logic [W-1:0] rdata
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    // Shadow register: follows every CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr)
            shadow_q <= wdata;
    end

    // Active register: direct write when unbuffered, boundary copy when buffered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (!buffered && wr)
            active_q <= wdata;
        else if (buffered && load_evt)
            active_q <= shadow_q;
    end

    // Readback: the register the CPU is writing in the current mode.
    always_comb begin
        rdata = buffered ? shadow_q : active_q;
    end

    assign active = active_q;

endmodule

// File: rtl/tcmp_block.sv
// Module tcmp_block
// Tracks the match blocking window opened by a counter write.
// Assumes cnt_wr is a single-cycle pulse; the window ends after one tick cycle.
module tcmp_block (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_wr,
    input  logic tick,
    output logic blocked
);

    logic pend_q;

    // Pending block: armed by a counter write, consumed by the next enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (cnt_wr)
            pend_q <= 1'b1;
        else if (tick)
            pend_q <= 1'b0;
    end

    // A write in progress also masks the cycle it occurs in.
    always_comb begin
        blocked = pend_q | cnt_wr;
    end

endmodule

// File: rtl/tcmp_match.sv
// Module tcmp_match
// Equality comparator qualified by the timer enable and the blocking window.
// Purely combinational; assumes both operands are registered upstream.
module tcmp_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] count_val,
    input  logic [W-1:0] cmp_val,
    input  logic         tick,
    input  logic         blocked,
    output logic         hit
);

    // Qualified equality.
    always_comb begin
        hit = tick && !blocked && (count_val == cmp_val);
    end

endmodule

// File: rtl/tcmp_wave.sv
// Module tcmp_wave
// Drives the output pin and the sticky match flag.
// Assumes force_evt is already gated off in PWM modes.
module tcmp_wave
    import tcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      force_evt,
    input  out_mode_e out_mode,
    input  logic      flag_clr,
    output logic      pin,
    output logic      flag
);

    logic pin_q;
    logic flag_q;

    // Pin: apply the selected action on a real or forced compare.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else if (hit || force_evt)
            pin_q <= pin_action(out_mode, pin_q);
    end

    // Flag: set by a real match only, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    assign pin  = pin_q;
    assign flag = flag_q;

endmodule

// File: rtl/timer_cmp_channel.sv
// Module timer_cmp_channel
// One output compare channel of a timer: compare register with mode-selected
// buffering, qualified comparator, pin/flag logic and counter-write blocking.
// Assumes the counter, top/bottom strobes and tick come from the timer core.
module timer_cmp_channel
    import tcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count_val,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [1:0]   wave_mode,
    input  logic [1:0]   out_mode,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_rdata,
    input  logic         cnt_wr,
    input  logic         force_cmp,
    input  logic         flag_clr,
    output logic         match_flag,
    output logic         pin_out
);

    wave_mode_e wm;
    out_mode_e  om;
    logic       pwm_mode;
    logic       load_evt;
    logic       force_evt;
    logic       blk_now;
    logic       cmp_hit;
    logic [W-1:0] active_cmp;

    // Mode decode and event qualification.
    always_comb begin
        wm        = wave_mode_e'(wave_mode);
        om        = out_mode_e'(out_mode);
        pwm_mode  = mode_is_pwm(wm);
        load_evt  = tick && ((wm == WM_PWM_FAST) ? at_top : at_bottom);
        force_evt = force_cmp && !pwm_mode;
    end

    tcmp_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .buffered (pwm_mode),
        .load_evt (load_evt),
        .wr       (cmp_wr),
        .wdata    (cmp_wdata),
        .active   (active_cmp),
        .rdata    (cmp_rdata)
    );

    tcmp_block u_block (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_wr  (cnt_wr),
        .tick    (tick),
        .blocked (blk_now)
    );

    tcmp_match #(.W(W)) u_match (
        .count_val (count_val),
        .cmp_val   (active_cmp),
        .tick      (tick),
        .blocked   (blk_now),
        .hit       (cmp_hit)
    );

    tcmp_wave u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (cmp_hit),
        .force_evt (force_evt),
        .out_mode  (om),
        .flag_clr  (flag_clr),
        .pin       (pin_out),
        .flag      (match_flag)
    );

endmodule

// File: rtl/tcmp_checker.sv
// Module tcmp_checker
// Concurrent properties for timer_cmp_channel, attached by bind.
module tcmp_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [W-1:0] count_val,
    input logic         at_top,
    input logic         at_bottom,
    input logic [1:0]   wave_mode,
    input logic [1:0]   out_mode,
    input logic         cmp_wr,
    input logic [W-1:0] cmp_wdata,
    input logic         cnt_wr,
    input logic         force_cmp,
    input logic         flag_clr,
    input logic         match_flag,
    input logic         pin_out,
    input logic [W-1:0] active_cmp,
    input logic         cmp_hit
);

    // R1 / R9: a qualified match always leaves the flag set.
    p_hit_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> match_flag);

    // R9: a clear with no match empties the flag.
    p_clear_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cmp_hit) |=> !match_flag);

    // R2: no enabled cycle means no new flag.
    p_no_tick_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !match_flag) |=> !match_flag);

    // R3: mode 00 never moves the pin.
    p_off_holds_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b00) |=> $stable(pin_out));

    // R4: unbuffered writes reach the active value at once.
    p_direct_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !wave_mode[0]) |=> (active_cmp == $past(cmp_wdata)));

    // R5: buffered active value holds away from top and bottom.
    p_no_midcycle_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode[0] && !at_top && !at_bottom) |=> $stable(active_cmp));

    // R7: a force without a tick never raises the flag.
    p_force_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !tick && !match_flag) |=> !match_flag);

    // R8: the enabled cycle after a counter write cannot match.
    p_write_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr ##1 (tick && !match_flag && !cnt_wr) |=> !match_flag);

endmodule

bind timer_cmp_channel tcmp_checker #(.W(W)) u_tcmp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .count_val  (count_val),
    .at_top     (at_top),
    .at_bottom  (at_bottom),
    .wave_mode  (wave_mode),
    .out_mode   (out_mode),
    .cmp_wr     (cmp_wr),
    .cmp_wdata  (cmp_wdata),
    .cnt_wr     (cnt_wr),
    .force_cmp  (force_cmp),
    .flag_clr   (flag_clr),
    .match_flag (match_flag),
    .pin_out    (pin_out),
    .active_cmp (active_cmp),
    .cmp_hit    (cmp_hit)
);

// File: tb/timer_cmp_channel_bench.sv
// Directed bench for timer_cmp_channel: one task per scenario.
module timer_cmp_channel_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [7:0] count_val;
    logic       at_top;
    logic       at_bottom;
    logic [1:0] wave_mode;
    logic [1:0] out_mode;
    logic       cmp_wr;
    logic [7:0] cmp_wdata;
    logic [7:0] cmp_rdata;
    logic       cnt_wr;
    logic       force_cmp;
    logic       flag_clr;
    logic       match_flag;
    logic       pin_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_cmp_channel u_timer_cmp_channel (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .count_val  (count_val),
        .at_top     (at_top),
        .at_bottom  (at_bottom),
        .wave_mode  (wave_mode),
        .out_mode   (out_mode),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .cmp_rdata  (cmp_rdata),
        .cnt_wr     (cnt_wr),
        .force_cmp  (force_cmp),
        .flag_clr   (flag_clr),
        .match_flag (match_flag),
        .pin_out    (pin_out)
    );

    // Record one comparison.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobes low, timer stopped.
    task automatic idle();
        tick = 0; at_top = 0; at_bottom = 0; cmp_wr = 0; cnt_wr = 0;
        force_cmp = 0; flag_clr = 0; count_val = 8'h00;
    endtask

    // Advance one edge and sample just after it.
    task automatic step();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic clear_flag();
        flag_clr = 1; step();
    endtask

    task automatic write_cmp(input logic [7:0] v);
        cmp_wr = 1; cmp_wdata = v; step();
    endtask

    task automatic tick_at(input logic [7:0] c);
        tick = 1; count_val = c; step();
    endtask

    task automatic t_reset();
        rst_n = 0; idle(); wave_mode = 2'b00; out_mode = 2'b00; cmp_wdata = 0;
        step(); step();
        rst_n = 1;
        check("R10 pin", pin_out, 0);
        check("R10 flag", match_flag, 0);
        check("R10 rdata", cmp_rdata, 0);
    endtask

    task automatic t_direct_and_set();
        wave_mode = 2'b00; out_mode = 2'b11;
        write_cmp(8'h40);
        check("R4 direct write / R6 readback", cmp_rdata, 8'h40);
        tick_at(8'h3F);
        check("R1 no match on unequal", match_flag, 0);
        tick_at(8'h40);
        check("R1 flag on match", match_flag, 1);
        check("R3 set action", pin_out, 1);
    endtask

    task automatic t_actions();
        clear_flag();
        check("R9 clear", match_flag, 0);
        out_mode = 2'b01;
        tick_at(8'h40);
        check("R3 toggle to 0", pin_out, 0);
        tick_at(8'h40);
        check("R3 toggle to 1", pin_out, 1);
        out_mode = 2'b10;
        tick = 1; count_val = 8'h40; flag_clr = 1; step();
        check("R9 match beats clear", match_flag, 1);
        check("R3 clear action", pin_out, 0);
        out_mode = 2'b00;
        clear_flag();
        tick_at(8'h40);
        check("R3 off keeps pin", pin_out, 0);
        check("R3 off still flags", match_flag, 1);
    endtask

    task automatic t_no_tick();
        clear_flag();
        count_val = 8'h40; step();
        check("R2 no tick no match", match_flag, 0);
    endtask

    task automatic t_force();
        wave_mode = 2'b10; out_mode = 2'b11;
        clear_flag();
        force_cmp = 1; step();
        check("R7 force drives pin", pin_out, 1);
        check("R7 force no flag", match_flag, 0);
        wave_mode = 2'b11; out_mode = 2'b10;
        force_cmp = 1; step();
        check("R7 force ignored in PWM", pin_out, 1);
        wave_mode = 2'b00;
    endtask

    task automatic t_block();
        out_mode = 2'b00; wave_mode = 2'b00;
        clear_flag();
        cnt_wr = 1; step();
        step();
        tick_at(8'h40);
        check("R8 blocked after write while stopped", match_flag, 0);
        tick_at(8'h40);
        check("R8 released after one tick", match_flag, 1);
    endtask

    task automatic t_fast_pwm();
        out_mode = 2'b00; wave_mode = 2'b11;
        write_cmp(8'h80);
        check("R6 PWM readback is shadow", cmp_rdata, 8'h80);
        clear_flag();
        tick_at(8'h40);
        check("R5 old active still used", match_flag, 1);
        clear_flag();
        tick = 1; at_bottom = 1; count_val = 8'h10; step();
        tick_at(8'h80);
        check("R5 fast ignores bottom", match_flag, 0);
        at_top = 1; count_val = 8'hFF; step();
        tick_at(8'h80);
        check("R5 top without tick no load", match_flag, 0);
        tick = 1; at_top = 1; count_val = 8'hFF; step();
        tick_at(8'h80);
        check("R5 fast loads at top", match_flag, 1);
        wave_mode = 2'b00; #1;
        check("R6 normal readback is active", cmp_rdata, 8'h80);
    endtask

    task automatic t_phase_pwm();
        wave_mode = 2'b01;
        write_cmp(8'h20);
        clear_flag();
        tick = 1; at_top = 1; count_val = 8'hFF; step();
        tick_at(8'h20);
        check("R5 phase ignores top", match_flag, 0);
        tick = 1; at_bottom = 1; count_val = 8'h00; step();
        tick_at(8'h20);
        check("R5 phase loads at bottom", match_flag, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_direct_and_set();
        t_actions();
        t_no_tick();
        t_force();
        t_block();
        t_fast_pwm();
        t_phase_pwm();
        finish_run();
    end

endmodule